// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Pulse Generator

This block is a clocked replacement for an RC-timed retriggerable monostable. It watches three asynchronous inputs: a trigger that acts on its falling edge, a trigger that acts on its rising edge, and an active-low clear. The clear also triggers on its rising edge. When one of these inputs makes a qualified transition, the block drives a single active-high pulse. The pulse lasts a number of clock cycles taken from a width input, and that width is captured at the moment of the trigger.

A qualified transition that arrives while the pulse is already running starts the count again from the full width. A steady train of triggers can therefore hold the output high for as long as it continues. A low level on the clear ends any pulse and blocks every trigger. Each input first passes through a multi-flop synchroniser. After reset, edge detection stays off until the synchronisers have filled, so input levels that are already present at reset cannot look like transitions.

Top module: `retrig_one_shot`

## Requirements
- R1: While `rst` is high and on the first sample after it, `pulse_out` is low.
- R2: For the first SYNC_STAGES+1 clock edges after reset is released, no pulse starts, even if the inputs sit at levels that would otherwise qualify (falling input low, rising input high, clear high).
- R3: A high-to-low change on `fall_trig_n` while `rise_trig` and `clear_n` are both high raises `pulse_out` at the third rising edge after the change (two synchroniser flops plus the output register).
- R4: A low-to-high change on `rise_trig` while `fall_trig_n` is low and `clear_n` is high raises `pulse_out` with the same three-edge latency.
- R5: A low-to-high change on `clear_n` while `fall_trig_n` is low and `rise_trig` is high raises `pulse_out` with the same three-edge latency.
- R6: Once a low on `clear_n` has passed the synchroniser, `pulse_out` is low at the next edge, and no input transition starts a pulse while the clear remains low.
- R7: A qualified trigger during a pulse reloads the counter with the current `width_cfg`. The output stays high for exactly that many more cycles, counted from the reload edge, and this holds also when the reload lands in the pulse's last cycle.
- R8: A trigger that samples `width_cfg` equal to zero has no effect: it starts no pulse and does not shorten or lengthen a running one.
- R9: Transitions that are not qualified (a rising `fall_trig_n`, a falling `rise_trig`, a trigger edge whose gating levels are wrong) start nothing. A pulse that has started runs to its normal end after the inputs move to non-triggering levels.
- R10: A pulse started with width W (1 to 2^WIDTH_W-1) is high for exactly W consecutive samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fall_trig_n | input | 1 | Asynchronous trigger, acts on its falling edge |
| rise_trig | input | 1 | Asynchronous trigger, acts on its rising edge |
| clear_n | input | 1 | Asynchronous clear, active low; its rising edge also triggers |
| width_cfg | input | WIDTH_W | Pulse length in clock cycles, sampled at each trigger |
| pulse_out | output | 1 | Active-high one-shot output |

## Verification
Two of the block's functions can fall in the same cycle:
- A retrigger can reload the counter in the same cycle that the counter would have expired. A directed case places the retrigger edge exactly two cycles before expiry. The bench then requires the output to stay high without a gap, for the new full width.
- The clear can go low in the same cycle as a trigger edge. In that case the clear must win, and the bench checks that the output drops and stays low.

Random stimulus with a fixed seed toggles all three inputs, with the clear dropping now and then, and changes the width every cycle. This mix also provokes both collisions. Every cycle is then compared with a bench model that applies the requirements cycle by cycle.

// File: rtl/opg_pkg.sv
package opg_pkg;

    // Bit positions of the three inputs inside the synchronised level bus
    localparam int unsigned IN_COUNT = 3;
    localparam int unsigned IX_FALL  = 0;
    localparam int unsigned IX_RISE  = 1;
    localparam int unsigned IX_CLR   = 2;

    // Which gated path produced a trigger in a given cycle
    typedef struct packed {
        logic from_fall;
        logic from_rise;
        logic from_clr;
    } trig_src_t;

endpackage

// File: rtl/opg_sync.sv
module opg_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [STAGES-1:0][N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/opg_trig.sv
module opg_trig
    import opg_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IN_COUNT-1:0] lvl,
    output logic                fire,
    output logic                clear
);

    localparam int unsigned WARM_W = $clog2(STAGES + 2);
    localparam logic [WARM_W-1:0] WARM_MAX = WARM_W'(STAGES + 1);

    typedef struct packed {
        logic [IN_COUNT-1:0] prev;
        logic [WARM_W-1:0]   warm;
    } trig_st_t;

    trig_st_t  st_d, st_q;
    trig_src_t src;
    logic      primed;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        if (st_q.warm != WARM_MAX) st_d.warm = st_q.warm + 1'b1;

        primed = (st_q.warm == WARM_MAX);

        src.from_fall = st_q.prev[IX_FALL] & ~lvl[IX_FALL]
                      & lvl[IX_RISE] & lvl[IX_CLR];
        src.from_rise = ~st_q.prev[IX_RISE] & lvl[IX_RISE]
                      & ~lvl[IX_FALL] & lvl[IX_CLR];
        src.from_clr  = ~st_q.prev[IX_CLR] & lvl[IX_CLR]
                      & ~lvl[IX_FALL] & lvl[IX_RISE];

        fire  = primed & (|src);
        clear = ~lvl[IX_CLR];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_WARMUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !primed |-> !fire); // R2
    AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !lvl[IX_CLR] |-> !fire); // R6
    AST_STATIC_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |-> (lvl != $past(lvl))); // R9

endmodule

// File: rtl/opg_timer.sv
module opg_timer #(
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               clear,
    input  logic [WIDTH_W-1:0] width,
    output logic               pulse
);

    localparam logic [WIDTH_W-1:0] ONE = WIDTH_W'(1);

    typedef struct packed {
        logic [WIDTH_W-1:0] cnt;
        logic               q;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (fire && (width != '0)) begin
            st_d.cnt = width;
            st_d.q   = 1'b1;
        end else if (st_q.q) begin
            st_d.cnt = st_q.cnt - ONE;
            st_d.q   = (st_q.cnt != ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pulse = st_q.q;

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!pulse && st_q.cnt == '0)); // R1
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pulse); // R6
    AST_LOAD_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear && width != '0) |=> (pulse && st_q.cnt == $past(width))); // R7
    AST_ZERO_NOP: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear && width == '0 && !pulse) |=> !pulse); // R8
    AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!pulse && !fire) |=> !pulse); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pulse && !clear && !(fire && width != '0)) |=> (st_q.cnt == $past(st_q.cnt) - ONE)); // R10

endmodule

// File: rtl/retrig_one_shot.sv
module retrig_one_shot
    import opg_pkg::*;
#(
    parameter int unsigned WIDTH_W     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fall_trig_n,
    input  logic               rise_trig,
    input  logic               clear_n,
    input  logic [WIDTH_W-1:0] width_cfg,
    output logic               pulse_out
);

    logic [IN_COUNT-1:0] raw_lvl, sync_lvl;
    logic                fire, clear;

    always_comb begin
        raw_lvl          = '0;
        raw_lvl[IX_FALL] = fall_trig_n;
        raw_lvl[IX_RISE] = rise_trig;
        raw_lvl[IX_CLR]  = clear_n;
    end

    opg_sync #(.N(IN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lvl),
        .dout (sync_lvl)
    );

    opg_trig #(.STAGES(SYNC_STAGES)) u_trig (
        .clk   (clk),
        .rst   (rst),
        .lvl   (sync_lvl),
        .fire  (fire),
        .clear (clear)
    );

    opg_timer #(.WIDTH_W(WIDTH_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .clear (clear),
        .width (width_cfg),
        .pulse (pulse_out)
    );

endmodule

// File: tb/sim_retrig_one_shot.sv
`timescale 1ns/1ps
module sim_retrig_one_shot;

    localparam int unsigned WW = 8;
    localparam int unsigned SS = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a = 1'b0, b = 1'b1, c = 1'b1;
    logic [WW-1:0] w = 8'd4;
    logic          pulse_out;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    retrig_one_shot #(.WIDTH_W(WW), .SYNC_STAGES(SS)) u0 (
        .clk(clk), .rst(rst), .fall_trig_n(a), .rise_trig(b),
        .clear_n(c), .width_cfg(w), .pulse_out(pulse_out)
    );

    // Reference model built from the requirements
    logic [2:0]    m1, m2, m3;
    int            mwarm;
    logic [WW-1:0] mcnt;

    function automatic logic qualified(logic [2:0] cur, logic [2:0] old);
        logic fa, rb, rc;
        fa = old[0] && !cur[0] && cur[1] && cur[2];
        rb = !old[1] && cur[1] && !cur[0] && cur[2];
        rc = !old[2] && cur[2] && !cur[0] && cur[1];
        return fa || rb || rc;
    endfunction

    function automatic logic [WW-1:0] next_cnt(logic [WW-1:0] cnt, logic clr_lo,
                                                logic trig, logic [WW-1:0] wid);
        if (clr_lo) return '0;
        if (trig && wid != 0) return wid;
        if (cnt != 0) return cnt - 1'b1;
        return cnt;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m1 <= '0; m2 <= '0; m3 <= '0; mwarm <= 0; mcnt <= '0;
        end else begin
            m1 <= {c, b, a};
            m2 <= m1;
            m3 <= m2;
            if (mwarm < SS + 1) mwarm <= mwarm + 1;
            mcnt <= next_cnt(mcnt, !m2[2],
                             (mwarm == SS + 1) && qualified(m2, m3), w);
        end
    end

    task automatic check(logic got, logic exp, string tag);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: pulse_out=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_low(int n, string tag);
        for (int i = 0; i < n; i++) begin tick(); check(pulse_out, 1'b0, tag); end
    endtask

    task automatic expect_high(int n, string tag);
        for (int i = 0; i < n; i++) begin tick(); check(pulse_out, 1'b1, tag); end
    endtask

    task automatic expect_pulse(int n, string tag);
        expect_low(2, tag);
        expect_high(n, tag);
        expect_low(1, tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset with trigger-ready levels present
        repeat (4) tick();
        check(pulse_out, 1'b0, "R1 during reset");
        @(negedge clk) rst = 1'b0;
        tick(); check(pulse_out, 1'b0, "R1 after reset");
        expect_low(10, "R2 static levels after reset");

        // R3 path
        a = 1; expect_low(6, "R9 rising on falling-trigger input");
        a = 0; expect_pulse(4, "R3");

        // R4 path
        b = 0; expect_low(5, "R9 falling on rising-trigger input");
        b = 1; expect_pulse(4, "R4");

        // R5 path
        c = 0; expect_low(5, "R6 clear held");
        c = 1; expect_pulse(4, "R5");

        // R10 extremes
        w = 1; a = 1; expect_low(3, "R10 setup");
        a = 0; expect_pulse(1, "R10 width one");
        w = 255; a = 1; expect_low(3, "R10 setup");
        a = 0; expect_pulse(255, "R10 width max");

        // R9 unqualified edges
        a = 1; b = 0; expect_low(4, "R9 setup");
        a = 0; expect_low(6, "R9 fall with rise input low");
        a = 1; expect_low(3, "R9 setup");
        b = 1; expect_low(6, "R9 rise with fall input high");

        // R9 pulse runs to end after inputs go idle
        w = 6; a = 0; expect_low(2, "R9 run to end");
        expect_high(1, "R9 run to end");
        a = 1; b = 0; expect_high(5, "R9 run to end");
        expect_low(1, "R9 run to end");
        b = 1; expect_low(3, "R9 setup");

        // R6 clear cuts a pulse and blocks triggers
        w = 10; a = 0; expect_low(2, "R6 setup");
        expect_high(4, "R6 setup");
        c = 0; expect_high(2, "R6 latency");
        expect_low(3, "R6 clear cuts pulse");
        a = 1; expect_low(1, "R6 blocked");
        a = 0; expect_low(1, "R6 blocked");
        b = 0; expect_low(1, "R6 blocked");
        b = 1; expect_low(5, "R6 blocked");
        a = 1; expect_low(2, "R6 setup");
        c = 1; expect_low(5, "R9 clear rise with fall input high");

        // R7 retrigger reloads with the new width
        w = 8; a = 0; expect_low(2, "R7 setup");
        expect_high(3, "R7 first pulse");
        a = 1; expect_high(1, "R7 first pulse");
        a = 0; w = 3; expect_high(2, "R7 before reload");
        expect_high(3, "R7 reloaded width");
        expect_low(1, "R7 reloaded end");

        // R7 reload on the final cycle of a pulse
        w = 4; a = 1; expect_low(3, "R7 setup");
        a = 0; expect_low(2, "R7 setup");
        expect_high(1, "R7 expiry collision");
        a = 1; expect_high(1, "R7 expiry collision");
        a = 0; expect_high(2, "R7 expiry collision");
        expect_high(4, "R7 expiry collision reload");
        expect_low(1, "R7 expiry collision end");

        // R8 zero width
        w = 0; a = 1; expect_low(3, "R8 setup");
        a = 0; expect_low(8, "R8 zero width no pulse");
        w = 6; a = 1; expect_low(2, "R8 setup");
        a = 0; expect_low(2, "R8 setup");
        expect_high(1, "R8 running");
        a = 1; expect_high(1, "R8 running");
        a = 0; w = 0; expect_high(4, "R8 zero retrigger ignored");
        expect_low(2, "R8 zero retrigger ignored");

        // Random phase compared against the model
        for (int k = 0; k < 4000; k++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 3) a = ~a;
            else if (r < 6) b = ~b;
            else if (r == 6) c = 1'b0;
            else if (r >= 13) c = 1'b1;
            w = WW'($urandom % 7);
            tick();
            check(pulse_out, (mcnt != 0), "random vs model");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule